// File: doc/BRIEF.md
# NMI Source Gating Controller

This block merges four hardware error sources into the single nonmaskable interrupt request line that goes to the processor. The four sources are a memory parity error, an I/O channel check, a bus channel time-out and a watchdog time-out. Each source is captured in its own sticky latch. Parity and channel-check events can be switched off one at a time through bits in a control port. They are also gated by a global mask bit that sits in the top bit of an index register. The two time-out sources cannot be masked, and they always reach the interrupt line.

When the interrupt line is seen high, the block raises an arbitration-hold output that freezes bus arbitration. Software releases it by writing 0 to bit 6 of the arbitration register. The same write also clears the two time-out latches. The control port also drives a one-cycle clear pulse for the timer 0 output latch and two static speaker controls.

All registers are reached through a simple byte-wide I/O bus with single-cycle write and read strobes. The interrupt handler reads the control port to see which maskable source fired.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: A one-cycle pulse on an enabled and unmasked parity or channel-check input sets that source's latch on the next clock edge, and `nmiReq` is high right after that edge.
- R2: The index register at address 0x70 resets to 0x80. Bit 7 is the global mask, and while it is 1 the parity and channel-check latches do not drive `nmiReq`, although the latches keep their state. Bits 6:0 read back as written.
- R3: A pulse on `wdTimeout` or `busTimeout` sets `nmiReq` on the next edge whatever the mask and enable bits hold.
- R4: Control-port (0x61) bit 2 disables parity and bit 3 disables channel check, both active high. A disable bit set to 1 blocks capture and clears that latch one edge after the register update. Both bits reset to 1.
- R5: A set latch keeps `nmiReq` high until that latch is cleared.
- R6: `arbHold` rises on the edge after `nmiReq` is high. It stays high until a write to 0x90 with bit 6 = 0, which clears `arbHold` and both time-out latches on that edge. A write with bit 6 = 1 changes nothing.
- R7: Writing 1 to control-port bit 7 gives a one-cycle `timer0LatchClr` pulse after the write edge. Reading the control port returns the parity latch in bit 7, the channel-check latch in bit 6 and the written bits 5:0.
- R8: `spkDataEn` follows the written control-port bit 1, and `tmr2SpkGate` follows bit 0.
- R9: `rst` clears all latches, `nmiReq`, `arbHold` and `timer0LatchClr`. It sets the index register to 0x80 and the control-port bits 5:0 to 0x0C.
- R10: A read of 0x90 returns `arbHold` in bit 6 and zeros elsewhere. `ioRdData` is 0 when `ioRdEn` is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| ioWrEn | input | 1 | One-cycle register write strobe |
| ioRdEn | input | 1 | Register read enable |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, combinational |
| parityErr | input | 1 | Memory parity error pulse |
| chanCheck | input | 1 | I/O channel check pulse |
| busTimeout | input | 1 | Bus channel time-out pulse |
| wdTimeout | input | 1 | Watchdog time-out pulse |
| nmiReq | output | 1 | Nonmaskable interrupt request |
| arbHold | output | 1 | Bus arbitration freeze |
| timer0LatchClr | output | 1 | One-cycle clear for the timer 0 output latch |
| spkDataEn | output | 1 | Speaker data enable |
| tmr2SpkGate | output | 1 | Timer 2 gate to speaker |

## Verification
Source latches and `nmiReq` respond one edge after a pulse. `arbHold` follows one edge after that, and the `timer0LatchClr` pulse appears one edge after its write. A disable bit clears its latch two edges after the write, because the control register itself must update first. `ioRdData` is combinational on the current state. The bench feeds inputs on the falling edge and steps a behavioural model on every rising edge. It compares all outputs 5 ns after each rising edge, so each result is taken in the cycle where it is due. Directed checks sample a fixed number of falling edges after each stimulus, following the same counts.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_INDEX = 2'd1,
    RD_PORTB = 2'd2,
    RD_ARB   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrIndex;
    logic   wrPortB;
    logic   arbRelease;
    logic   t0Pulse;
    rdSel_e rdSel;
  } nmiStrobe_t;

endpackage

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
  import nmi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h0070,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 'h0061,
  parameter logic [ADDR_W-1:0] ARB_ADDR   = 'h0090
) (
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              arbBit,
  input  logic              t0Bit,
  output nmiStrobe_t        strb
);

  logic hitIndex, hitPortB, hitArb;

  assign hitIndex = (ioAddr == INDEX_ADDR);
  assign hitPortB = (ioAddr == PORTB_ADDR);
  assign hitArb   = (ioAddr == ARB_ADDR);

  always_comb begin
    strb            = '0;
    strb.wrIndex    = ioWrEn & hitIndex;
    strb.wrPortB    = ioWrEn & hitPortB;
    strb.arbRelease = ioWrEn & hitArb & ~arbBit;
    strb.t0Pulse    = ioWrEn & hitPortB & t0Bit;
    strb.rdSel      = RD_NONE;
    if (ioRdEn) begin
      if (hitIndex)      strb.rdSel = RD_INDEX;
      else if (hitPortB) strb.rdSel = RD_PORTB;
      else if (hitArb)   strb.rdSel = RD_ARB;
    end
  end

endmodule

// File: rtl/nmi_datapath.sv
module nmi_datapath
  import nmi_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_SRC   = 4,
  parameter logic [NUM_SRC-1:0] MASKABLE = 4'b0011,
  parameter int DIS_BASE  = 2,
  parameter int MASK_BIT  = 7,
  parameter int ARB_BIT   = 6,
  parameter logic [DATA_W-1:0] IDX_RESET = 8'h80,
  parameter logic [DATA_W-3:0] PB_RESET  = 6'h0C
) (
  input  logic               clk,
  input  logic               rst,
  input  nmiStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               nmiReq,
  output logic               arbHold,
  output logic               timer0LatchClr,
  output logic               spkDataEn,
  output logic               tmr2SpkGate
);

  localparam int CTL_W = DATA_W - 2;

  logic [DATA_W-1:0]  idxReg;
  logic [CTL_W-1:0]   pbCtl;
  logic [NUM_SRC-1:0] srcLatch;
  logic [NUM_SRC-1:0] srcQual;
  logic               arbHoldQ;
  logic               t0Q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic latchQ;
      if (MASKABLE[i]) begin : g_mask
        logic srcDis;
        assign srcDis = pbCtl[DIS_BASE+i];
        always_ff @(posedge clk) begin
          if (rst)           latchQ <= 1'b0;
          else if (srcDis)   latchQ <= 1'b0;
          else if (srcIn[i]) latchQ <= 1'b1;
        end
        assign srcQual[i] = latchQ & ~idxReg[MASK_BIT];
      end else begin : g_fixed
        always_ff @(posedge clk) begin
          if (rst)                  latchQ <= 1'b0;
          else if (strb.arbRelease) latchQ <= 1'b0;
          else if (srcIn[i])        latchQ <= 1'b1;
        end
        assign srcQual[i] = latchQ;
      end
      assign srcLatch[i] = latchQ;
    end
  endgenerate

  assign nmiReq = |srcQual;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg   <= IDX_RESET;
      pbCtl    <= PB_RESET;
      arbHoldQ <= 1'b0;
      t0Q      <= 1'b0;
    end else begin
      if (strb.wrIndex) idxReg <= wrData;
      if (strb.wrPortB) pbCtl  <= wrData[CTL_W-1:0];
      if (strb.arbRelease) arbHoldQ <= 1'b0;
      else if (nmiReq)     arbHoldQ <= 1'b1;
      t0Q <= strb.t0Pulse;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_INDEX: rdData = idxReg;
      RD_PORTB: rdData = {srcLatch[0], srcLatch[1], pbCtl};
      RD_ARB:   rdData[ARB_BIT] = arbHoldQ;
      default:  rdData = '0;
    endcase
  end

  assign arbHold        = arbHoldQ;
  assign timer0LatchClr = t0Q;
  assign spkDataEn      = pbCtl[1];
  assign tmr2SpkGate    = pbCtl[0];

  // R3
  wd_reach_chk: assert property (@(posedge clk) disable iff (rst)
    (srcIn[NUM_SRC-1] && !strb.arbRelease) |=> nmiReq);

  // R6
  hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (arbHoldQ && !strb.arbRelease) |=> arbHoldQ);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    strb.arbRelease |=> !arbHoldQ);

  // R4
  par_dis_chk: assert property (@(posedge clk) disable iff (rst)
    pbCtl[DIS_BASE] |=> !srcLatch[0]);

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (idxReg[MASK_BIT] && !srcLatch[NUM_SRC-1] && !srcLatch[NUM_SRC-2]) |-> !nmiReq);

  // R7
  t0_origin_chk: assert property (@(posedge clk) disable iff (rst)
    t0Q |-> $past(strb.wrPortB));

endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
  import nmi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic              parityErr,
  input  logic              chanCheck,
  input  logic              busTimeout,
  input  logic              wdTimeout,
  output logic              nmiReq,
  output logic              arbHold,
  output logic              timer0LatchClr,
  output logic              spkDataEn,
  output logic              tmr2SpkGate
);

  localparam int ARB_BIT = 6;
  localparam int T0_BIT  = DATA_W - 1;

  nmiStrobe_t strb;
  logic [3:0] srcIn;

  assign srcIn = {wdTimeout, busTimeout, chanCheck, parityErr};

  nmi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .ioWrEn (ioWrEn),
    .ioRdEn (ioRdEn),
    .ioAddr (ioAddr),
    .arbBit (ioWrData[ARB_BIT]),
    .t0Bit  (ioWrData[T0_BIT]),
    .strb   (strb)
  );

  nmi_datapath #(.DATA_W(DATA_W), .ARB_BIT(ARB_BIT), .MASK_BIT(T0_BIT)) u_dp (
    .clk            (clk),
    .rst            (rst),
    .strb           (strb),
    .wrData         (ioWrData),
    .srcIn          (srcIn),
    .rdData         (ioRdData),
    .nmiReq         (nmiReq),
    .arbHold        (arbHold),
    .timer0LatchClr (timer0LatchClr),
    .spkDataEn      (spkDataEn),
    .tmr2SpkGate    (tmr2SpkGate)
  );

endmodule

// File: tb/tb_nmi_gate_ctrl.sv
module tb_nmi_gate_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        parityErr = 0, chanCheck = 0, busTimeout = 0, wdTimeout = 0;
  logic        nmiReq, arbHold, timer0LatchClr, spkDataEn, tmr2SpkGate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  nmi_gate_ctrl dut (.*);

  // behavioural reference state
  logic [7:0] mIdx;
  logic [5:0] mPb;
  logic mPar, mChk, mTo, mWd, mArb, mT0;

  function automatic logic mNmi();
    return ((mPar | mChk) & ~mIdx[7]) | mTo | mWd;
  endfunction

  function automatic logic [7:0] mRead();
    if (!ioRdEn) return 8'h00;
    case (ioAddr)
      16'h0070: return mIdx;
      16'h0061: return {mPar, mChk, mPb};
      16'h0090: return {1'b0, mArb, 6'b0};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic oldNmi, rel;
    oldNmi = mNmi();
    rel = ioWrEn && ioAddr == 16'h0090 && !ioWrData[6];
    if (rst) begin
      mIdx = 8'h80; mPb = 6'h0C;
      {mPar, mChk, mTo, mWd, mArb, mT0} = '0;
    end else begin
      mArb = rel ? 1'b0 : (mArb | oldNmi);
      mPar = mPb[2] ? 1'b0 : (mPar | parityErr);
      mChk = mPb[3] ? 1'b0 : (mChk | chanCheck);
      mTo  = rel ? 1'b0 : (mTo | busTimeout);
      mWd  = rel ? 1'b0 : (mWd | wdTimeout);
      mT0  = ioWrEn && ioAddr == 16'h0061 && ioWrData[7];
      if (ioWrEn && ioAddr == 16'h0070) mIdx = ioWrData;
      if (ioWrEn && ioAddr == 16'h0061) mPb  = ioWrData[5:0];
    end
  end

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (!rst && !done) begin
      check("R1 R5 nmiReq model", {7'b0, nmiReq}, {7'b0, mNmi()});
      check("R6 arbHold model", {7'b0, arbHold}, {7'b0, mArb});
      check("R7 timer0LatchClr model", {7'b0, timer0LatchClr}, {7'b0, mT0});
      check("R8 speaker model", {6'b0, spkDataEn, tmr2SpkGate}, {6'b0, mPb[1:0]});
      check("R10 read model", ioRdData, mRead());
    end
  end

  task automatic ioWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); ioWrEn = 1; ioAddr = a; ioWrData = d;
    @(negedge clk); ioWrEn = 0; ioAddr = '0; ioWrData = '0;
  endtask

  task automatic readCheck(string tag, logic [15:0] a, logic [7:0] exp);
    @(negedge clk); ioRdEn = 1; ioAddr = a;
    #2 check(tag, ioRdData, exp);
    @(negedge clk); ioRdEn = 0; ioAddr = '0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: parityErr = 1; 1: chanCheck = 1; 2: busTimeout = 1; default: wdTimeout = 1;
    endcase
    @(negedge clk); {parityErr, chanCheck, busTimeout, wdTimeout} = '0;
  endtask

  task automatic outCheck(string tag, logic act, logic exp);
    #1 check(tag, {7'b0, act}, {7'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    outCheck("R9 nmiReq after reset", nmiReq, 0);
    outCheck("R9 arbHold after reset", arbHold, 0);
    readCheck("R9 R2 index reset", 16'h0070, 8'h80);
    readCheck("R9 R4 port B reset", 16'h0061, 8'h0C);
    readCheck("R10 unmapped read", 16'h0042, 8'h00);

    // parity blocked while disabled
    pulse(0);
    outCheck("R4 disabled parity no NMI", nmiReq, 0);
    readCheck("R4 disabled parity not latched", 16'h0061, 8'h0C);

    // enable, unmask, parity fires
    ioWrite(16'h0061, 8'h00);
    ioWrite(16'h0070, 8'h05);
    readCheck("R2 index readback", 16'h0070, 8'h05);
    pulse(0);
    outCheck("R1 parity raises NMI", nmiReq, 1);
    readCheck("R7 parity status bit", 16'h0061, 8'h80);

    // mask hides it but latch stays
    ioWrite(16'h0070, 8'h85);
    outCheck("R2 mask suppresses parity", nmiReq, 0);
    readCheck("R2 latch kept under mask", 16'h0061, 8'h80);
    ioWrite(16'h0061, 8'h04);
    readCheck("R4 disable clears parity latch", 16'h0061, 8'h04);
    ioWrite(16'h0090, 8'h00);

    // watchdog ignores mask
    pulse(3);
    outCheck("R3 watchdog unmaskable", nmiReq, 1);
    @(negedge clk);
    outCheck("R6 arbHold raised", arbHold, 1);
    repeat (4) @(negedge clk);
    outCheck("R5 NMI sticky", nmiReq, 1);
    ioWrite(16'h0090, 8'h40);
    outCheck("R6 bit6=1 write keeps hold", arbHold, 1);
    readCheck("R10 arb read", 16'h0090, 8'h40);
    ioWrite(16'h0090, 8'h00);
    outCheck("R6 release clears hold", arbHold, 0);
    outCheck("R6 release clears watchdog", nmiReq, 0);

    // bus time-out ignores mask and disables
    ioWrite(16'h0061, 8'h0C);
    pulse(2);
    outCheck("R3 bus time-out unmaskable", nmiReq, 1);
    ioWrite(16'h0090, 8'h00);
    outCheck("R6 release clears time-out", nmiReq, 0);

    // timer0 pulse and speaker bits
    ioWrite(16'h0061, 8'h83);
    outCheck("R7 timer0 pulse high", timer0LatchClr, 1);
    outCheck("R8 speaker data enable", spkDataEn, 1);
    outCheck("R8 timer2 gate", tmr2SpkGate, 1);
    @(negedge clk);
    outCheck("R7 timer0 pulse one cycle", timer0LatchClr, 0);
    readCheck("R7 bit7 reads status", 16'h0061, 8'h03);

    // channel check path
    ioWrite(16'h0061, 8'h00);
    ioWrite(16'h0070, 8'h05);
    pulse(1);
    outCheck("R1 channel check raises NMI", nmiReq, 1);
    readCheck("R7 channel status bit", 16'h0061, 8'h40);
    ioWrite(16'h0061, 8'h08);
    @(negedge clk);
    outCheck("R4 channel disable drops NMI", nmiReq, 0);
    outCheck("R6 hold survives source clear", arbHold, 1);
    ioWrite(16'h0090, 8'h00);

    // reset mid-activity
    pulse(3);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    outCheck("R9 reset clears NMI", nmiReq, 0);
    outCheck("R9 reset clears hold", arbHold, 0);
    readCheck("R9 index after reset", 16'h0070, 8'h80);
    readCheck("R9 port B after reset", 16'h0061, 8'h0C);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule